// File: doc/BRIEF.md
# SMBus Indexed Register Slave for a Clock Fan-out Controller

This block is a slave-only SMBus target that holds the small bank of 8-bit control registers of a four-output differential clock fan-out device. It answers one fixed 7-bit address. A host writes a group of registers by sending a starting offset, a byte count and then that many bytes. The registers are filled one after another from the offset. A host reads by addressing the slave with the read bit set. The slave then sends a byte count, followed by register bytes taken from the current pointer for as long as the host acknowledges.

The bus is open-drain. The block receives the sampled SCL and SDA levels, and it has one pull-low output that the pad turns into an SDA output enable. Both lines pass through a two-flop synchronizer and a glitch filter, all clocked by a fast system clock. The register contents leave the block as a flat parallel vector that feeds the clock-path logic. Register 0 holds the output mode, the PLL/fan-out selection, the bandwidth and the two tristate-when-stopped bits. Register 1 holds the per-output enables and register 2 the per-output stop permits. Register 3 is a fixed identification byte.

Top module: `smb_regbank`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 7'b1101110. For any other address it leaves SDA released during the acknowledge bit and stays off the bus until the next start.
- R2: In a write frame (address bit 0 = 0), the slave acknowledges the offset byte and a nonzero count N, then acknowledges N data bytes. Data byte k goes to register offset+k.
- R3: A count byte of zero in a write frame is not acknowledged. No data byte after it is acknowledged or stored.
- R4: Data bytes beyond the N-th in a write frame are not acknowledged and are not stored.
- R5: In a read frame (address bit 0 = 1), the slave first sends a count byte equal to 4, the number of registers. It then sends register bytes from the pointer for as long as the host acknowledges. After a host no-acknowledge it releases SDA.
- R6: The offset byte loads the register pointer. The pointer advances by one for each data byte written or sent, and a read frame starts at the current pointer.
- R7: After reset the registers read 0x07, 0x66, 0x00 and 0x20 for registers 0 to 3. regs_o[8*i+7:8*i] carries register i.
- R8: Only register 0 bits 0,1,2,6,7 and register 1 and 2 bits 1,2,5,6 are writable. All other bits of registers 0 to 2 read 0 and ignore writes. Register 3 always reads 0x20.
- R9: Offsets 4 and above read as 0x00. Bytes written to them are acknowledged and dropped.
- R10: A start (including a repeated start) or a stop at any point ends the current transfer and releases SDA. A start begins a new address phase, and bytes already stored stay stored.
- R11: A low or high pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transfer.
- R12: The slave starts pulling SDA low only just after a falling edge of SCL, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (pad output enable, data 0) |
| regs_o | output | 32 | Register bank, register i in bits 8*i+7:8*i |

## Verification
The assertions check four properties on every cycle. The identification byte and the reserved bits never move. The register bank changes only on a write strobe. SDA pull-down starts only after an SCL fall. A start or stop always leaves SDA released and the state machine where it should be. The bench's scenarios cover the rest. These are the address match across all 128 addresses, the masking of written patterns, reads from every offset (including those past the bank), zero and excess counts, aborts part-way through a frame, and the rejection of short pulses. Each of these depends on a whole frame and cannot be seen in a single cycle.

// File: rtl/smbrb_pkg.sv
package smbrb_pkg;

    localparam int NUM_REGS = 4;
    localparam int REG_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_WAIT
    } smb_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_OFFS,
        PH_CNT,
        PH_WDAT
    } smb_phase_e;

    typedef struct packed {
        smb_state_e state;
        smb_phase_e phase;
        smb_state_e ack_next;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic [7:0] txsh;
        logic [7:0] ptr;
        logic [7:0] remain;
        logic       mack;
        logic       pull;
    } smb_fsm_t;

    // Power-up value of each register
    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'h66;
            2:       return 8'h00;
            3:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // Bits that a host write may change
    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'hC7;
            1:       return 8'h66;
            2:       return 8'h66;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbrb_glitch_filter.sv
module smbrb_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          level;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_i};
        if (q.sync[1] != q.level) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.level = q.sync[1];
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, cnt: '0, level: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign line_o = q.level;
endmodule

// File: rtl/smbrb_bus_cond.sv
module smbrb_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  =  scl_f & ~scl_q;
    assign scl_fall  = ~scl_f &  scl_q;
    assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
    assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;
endmodule

// File: rtl/smbrb_regfile.sv
module smbrb_regfile
    import smbrb_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [7:0]     waddr,
    input  logic [7:0]     wdata,
    input  logic [7:0]     raddr,
    output logic [7:0]     rdata,
    output logic [N*8-1:0] regs_flat
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [7:0] regs_q [N];
    logic [7:0] regs_d [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_reg
        always_comb begin
            regs_d[gi] = regs_q[gi];
            if (we && waddr == 8'(gi)) begin
                regs_d[gi] = (regs_q[gi] & ~reg_wmask(gi)) | (wdata & reg_wmask(gi));
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[gi] <= reg_reset(gi);
            end else begin
                regs_q[gi] <= regs_d[gi];
            end
        end

        assign regs_flat[gi*8 +: 8] = regs_q[gi];
    end

    assign rdata = (raddr < 8'(N)) ? regs_q[raddr[IW-1:0]] : 8'h00;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smbrb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'b1101110,
    parameter int         FILT_LEN   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic reg_we;
    logic [7:0] rdata;
    smb_state_e cur_state;

    smb_fsm_t q, d;

    smbrb_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );

    smbrb_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    smbrb_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smbrb_regfile #(.N(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we),
        .waddr(q.ptr), .wdata(q.shreg), .raddr(q.ptr),
        .rdata(rdata), .regs_flat(regs_o)
    );

    always_comb begin
        d      = q;
        reg_we = 1'b0;
        if (start_det) begin
            d.state  = ST_RX;
            d.phase  = PH_ADDR;
            d.bitcnt = '0;
            d.pull   = 1'b0;
        end else if (stop_det) begin
            d.state = ST_IDLE;
            d.pull  = 1'b0;
        end else begin
            case (q.state)
                ST_RX: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_f};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        case (q.phase)
                            PH_ADDR: begin
                                if (q.shreg[7:1] == SLAVE_ADDR) begin
                                    d.pull  = 1'b1;
                                    d.state = ST_ACK;
                                    if (q.shreg[0]) begin
                                        d.ack_next = ST_TX;
                                        d.txsh     = CNT_BYTE;
                                    end else begin
                                        d.ack_next = ST_RX;
                                        d.phase    = PH_OFFS;
                                    end
                                end else begin
                                    d.state = ST_WAIT;
                                end
                            end
                            PH_OFFS: begin
                                d.ptr      = q.shreg;
                                d.pull     = 1'b1;
                                d.state    = ST_ACK;
                                d.ack_next = ST_RX;
                                d.phase    = PH_CNT;
                            end
                            PH_CNT: begin
                                if (q.shreg == 8'h00) begin
                                    d.state = ST_WAIT;
                                end else begin
                                    d.remain   = q.shreg;
                                    d.pull     = 1'b1;
                                    d.state    = ST_ACK;
                                    d.ack_next = ST_RX;
                                    d.phase    = PH_WDAT;
                                end
                            end
                            default: begin
                                reg_we     = 1'b1;
                                d.ptr      = q.ptr + 1'b1;
                                d.remain   = q.remain - 1'b1;
                                d.pull     = 1'b1;
                                d.state    = ST_ACK;
                                d.ack_next = (q.remain == 8'd1) ? ST_WAIT : ST_RX;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.pull  = 1'b0;
                        d.state = q.ack_next;
                        if (q.ack_next == ST_TX) begin
                            d.pull   = ~q.txsh[7];
                            d.bitcnt = '0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.pull  = 1'b0;
                            d.state = ST_TXACK;
                        end else begin
                            d.txsh   = q.txsh << 1;
                            d.pull   = ~q.txsh[6];
                            d.bitcnt = q.bitcnt + 1'b1;
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_f;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.txsh   = rdata;
                            d.ptr    = q.ptr + 1'b1;
                            d.pull   = ~rdata[7];
                            d.bitcnt = '0;
                            d.state  = ST_TX;
                        end else begin
                            d.state = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: PH_ADDR, ack_next: ST_IDLE,
                   bitcnt: '0, shreg: '0, txsh: '0, ptr: '0, remain: '0,
                   mack: 1'b0, pull: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign cur_state  = q.state;
endmodule

// File: rtl/smbrb_checker.sv
module smbrb_checker
    import smbrb_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_pull,
    input logic                  scl_fall,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  reg_we,
    input smb_state_e            state,
    input logic [NUM_REGS*8-1:0] regs
);
    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        regs[31:24] == 8'h20); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[5:3] == 3'b000) && ((regs[15:8] & 8'h99) == 8'h00)
        && ((regs[23:16] & 8'h99) == 8'h00)); // R8

    AST_REG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs) |-> $past(reg_we)); // R2

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall)); // R12

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> !sda_pull && state == ST_IDLE); // R10

    AST_START_NEW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull && state == ST_RX); // R10

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_IDLE) |-> !sda_pull); // R1
endmodule

bind smb_regbank smbrb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_pull (sda_pull_o),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .reg_we   (reg_we),
    .state    (cur_state),
    .regs     (regs_o)
);

// File: tb/tb_smb_regbank.sv
`timescale 1ns/1ps
module tb_smb_regbank;
    localparam int Q  = 10;
    localparam int FL = 3;
    localparam logic [6:0] ADR = 7'b1101110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic glitch = 1'b0;
    logic sda_pull;
    logic [31:0] regs;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int r12_viol = 0;
    bit done = 0;

    logic [7:0] exp_r [4];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic [7:0] rcnt;
    logic       ackv [12];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    smb_regbank #(.SLAVE_ADDR(ADR), .FILT_LEN(FL)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .regs_o(regs)
    );

    // Independent watch of R12: pull must not start while SCL is high
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_pull && !pull_prev && scl_m) r12_viol++;
        pull_prev <= sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wmask(input int k);
        if (k == 0) return 8'hC7;
        if (k == 1 || k == 2) return 8'h66;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_rd(input int k);
        return (k < 4) ? exp_r[k] : 8'h00;
    endfunction

    function automatic logic [31:0] exp_vec();
        return {exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
    endfunction

    task automatic model_wr(input int k, input logic [7:0] v);
        if (k < 4) exp_r[k] = (exp_r[k] & ~wmask(k)) | (v & wmask(k));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(6);
            if (glitch) begin
                scl_m = 1'b0; tick(FL - 1); scl_m = 1'b1;
                if (b[i]) begin sda_m = 1'b0; tick(FL - 1); sda_m = 1'b1; end
                else tick(FL - 1);
            end else tick(2*(FL - 1));
            tick(2*Q - 6 - 2*(FL - 1));
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic do_write(input logic [7:0] offs, input logic [7:0] cnt, input int nsend);
        bus_start();
        send_byte({ADR, 1'b0}, ackv[0]);
        send_byte(offs, ackv[1]);
        send_byte(cnt, ackv[2]);
        for (int i = 0; i < nsend; i++) send_byte(wbuf[i], ackv[3+i]);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] offs, input int n);
        logic a;
        bus_start();
        send_byte({ADR, 1'b0}, a);
        send_byte(offs, a);
        bus_stop();
        bus_start();
        send_byte({ADR, 1'b1}, ackv[0]);
        recv_byte(1'b1, rcnt);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    initial begin
        for (int k = 0; k < 4; k++) exp_r[k] = (k == 0) ? 8'h07 : (k == 1) ? 8'h66 : (k == 3) ? 8'h20 : 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R7: reset contents and quiet bus
        chk("R7 reset regs", regs, 32'h2000_6607);
        chk("R7 reset pull", {31'b0, sda_pull}, 32'h0);

        // R1: sweep of every address with the write bit
        for (int a = 0; a < 128; a++) begin
            logic ak;
            bus_start();
            send_byte({a[6:0], 1'b0}, ak);
            bus_stop();
            chk($sformatf("R1 ack addr %02h", a), {31'b0, ak}, {31'b0, (a[6:0] == ADR)});
        end
        chk("R1 released after sweep", {31'b0, sda_pull}, 32'h0);

        // R2 R8: full-bank writes with several patterns
        for (int p = 0; p < 6; p++) begin
            logic [7:0] base;
            base = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 :
                   (p == 3) ? 8'h5A : (p == 4) ? 8'h3C : 8'hC3;
            for (int i = 0; i < 4; i++) wbuf[i] = base ^ 8'(i * 17);
            do_write(8'h00, 8'd4, 4);
            for (int i = 0; i < 4; i++) model_wr(i, wbuf[i]);
            chk("R2 acks", {28'b0, ackv[3], ackv[4], ackv[5], ackv[6]}, 32'hF);
            chk("R8 masked contents", regs, exp_vec());
        end

        // R5 R6 R9 R12: reads from every offset, including past the bank
        for (int o = 0; o < 6; o++) begin
            do_read(8'(o), 4);
            chk("R5 read addr ack", {31'b0, ackv[0]}, 32'h1);
            chk("R5 count byte", {24'b0, rcnt}, 32'd4);
            for (int i = 0; i < 4; i++)
                chk($sformatf("R6 R9 R12 read off %0d byte %0d", o, i), {24'b0, rbuf[i]}, {24'b0, exp_rd(o + i)});
        end

        // R9: write straddling the end of the bank
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hFF;
        do_write(8'h02, 8'd4, 4);
        for (int i = 0; i < 4; i++) model_wr(2 + i, wbuf[i]);
        chk("R9 acks past end", {28'b0, ackv[3], ackv[4], ackv[5], ackv[6]}, 32'hF);
        chk("R9 regs", regs, exp_vec());

        // R3: zero count
        wbuf[0] = 8'h00;
        do_write(8'h00, 8'd0, 1);
        chk("R3 zero count nack", {31'b0, ackv[2]}, 32'h0);
        chk("R3 no data ack", {31'b0, ackv[3]}, 32'h0);
        chk("R3 regs unchanged", regs, exp_vec());

        // R4: bytes past the count
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
        do_write(8'h01, 8'd1, 3);
        model_wr(1, 8'h00);
        chk("R4 acks", {29'b0, ackv[3], ackv[4], ackv[5]}, 32'h4);
        chk("R4 regs", regs, exp_vec());

        // R10: repeated start part-way through a write
        begin
            logic a;
            bus_start();
            send_byte({ADR, 1'b0}, a);
            send_byte(8'h00, a);
            send_byte(8'd3, a);
            send_byte(8'h00, a);
            model_wr(0, 8'h00);
            bus_start();
            send_byte({ADR, 1'b1}, ackv[0]);
            recv_byte(1'b0, rcnt);
            bus_stop();
            chk("R10 restart addr ack", {31'b0, ackv[0]}, 32'h1);
            chk("R10 restart count", {24'b0, rcnt}, 32'd4);
            chk("R10 kept bytes", regs, exp_vec());
        end

        // R10: stop part-way through a write
        begin
            logic a;
            bus_start();
            send_byte({ADR, 1'b0}, a);
            send_byte(8'h02, a);
            send_byte(8'd2, a);
            send_byte(8'h66, a);
            model_wr(2, 8'h66);
            bus_stop();
            chk("R10 stop release", {31'b0, sda_pull}, 32'h0);
            chk("R10 stop kept", regs, exp_vec());
        end

        // R11: short pulses on both lines during every bit
        glitch = 1'b1;
        wbuf[0] = 8'hC7; wbuf[1] = 8'h66; wbuf[2] = 8'h22;
        do_write(8'h00, 8'd3, 3);
        glitch = 1'b0;
        for (int i = 0; i < 3; i++) model_wr(i, wbuf[i]);
        chk("R11 glitch acks", {29'b0, ackv[3], ackv[4], ackv[5]}, 32'h7);
        chk("R11 glitch regs", regs, exp_vec());

        chk("R12 pull start while SCL high", r12_viol, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule